// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This unit adds or subtracts two numbers held in signed-magnitude form: a sign bit on top (1 means negative) over an unsigned magnitude field. By default each operand is 8 bits wide, a sign bit over a 7-bit magnitude. An operation bit selects the operation: 0 adds the second operand to the first, and 1 subtracts it. The unit XORs the operation bit with both operand signs. When that parity is 0 the magnitudes are added. When it is 1 the second magnitude is subtracted from the first, and a borrow is undone by negating the difference and inverting the sign.

The arithmetic is a single combinational path feeding one result register. Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The input is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty, or when its contents are being taken on the same edge. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operands are taken. One transfer in gives exactly one result out, and results leave in the order the operands arrived.

Top module: `sm_addsub_unit`

## Requirements
- R1: When sign(a) XOR sign(b) XOR op is 0, the result magnitude is the sum of the two magnitudes. Operands are formatted {sign, magnitude}, with sign in the top bit and 1 meaning negative, and op is 0 for add and 1 for subtract.
- R2: When the parity is 0, the result sign equals the sign of operand a. This holds even when both magnitudes are zero.
- R3: When the parity is 0 and the magnitude sum does not fit in MAG_W bits, `out_ovf` is 1 and the magnitude is the sum modulo 2^MAG_W. Otherwise `out_ovf` is 0.
- R4: When the parity is 1 and mag(a) >= mag(b), the magnitude is mag(a) - mag(b) and the sign is sign(a), unless R7 applies.
- R5: When the parity is 1 and mag(a) < mag(b), the magnitude is mag(b) - mag(a) and the sign is the inverse of sign(a).
- R6: When the parity is 1, `out_ovf` is always 0.
- R7: When the parity is 1 and the resulting magnitude is zero, the result sign is 0.
- R8: An operand with sign 1 and magnitude 0 is treated as zero magnitude, and its sign still takes part in the parity.
- R9: An input is taken on a rising edge with `in_valid` and `in_ready` high, and its result is presented with `out_valid` on the next cycle. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and op are valid |
| in_ready | output | 1 | Unit can take operands this cycle |
| in_a | input | MAG_W+1 | First operand, {sign, magnitude} |
| in_b | input | MAG_W+1 | Second operand, {sign, magnitude} |
| in_op | input | 1 | 0 = add, 1 = subtract |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Result sign |
| out_mag | output | MAG_W | Result magnitude |
| out_ovf | output | 1 | Magnitude overflow on the add path |

## Verification
Each result is due exactly one rising edge after its operands are accepted. It stays on the outputs until a rising edge with `out_ready` high consumes it. The bench records the expected value at the moment of acceptance: inputs are set on the falling edge, and `in_ready` is sampled just after, so it has settled before the next rising edge. The comparison is made at a falling edge where `out_valid` and `out_ready` are both high, which is the cycle in which the result is handed over. That keeps the order of the expected queue and the design's output in step, even under random back-pressure. During stalls, the bench also checks that the held result does not change from one falling edge to the next.

// File: rtl/sm_pkg.sv
package sm_pkg;

  // which magnitude operation the sign parity selects
  typedef enum logic {
    SM_PATH_ADD = 1'b0,
    SM_PATH_SUB = 1'b1
  } sm_path_e;

endpackage

// File: rtl/sm_path_select.sv
module sm_path_select
  import sm_pkg::*;
(
  input  logic     sign_a,
  input  logic     sign_b,
  input  logic     op_sub,
  output sm_path_e path
);

  // three-way parity of both signs and the operation bit
  logic parity;

  always_comb begin
    parity = sign_a ^ sign_b ^ op_sub;
    path   = parity ? SM_PATH_SUB : SM_PATH_ADD;
  end

endmodule

// File: rtl/sm_mag_adder.sv
module sm_mag_adder #(
  parameter int WIDTH = 7
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  // ripple chain; sub inverts b and injects a carry of one
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_eff;

  assign carry[0] = sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic gen_i;
    logic prop_i;
    assign b_eff[i]    = b[i] ^ sub;
    assign gen_i       = a[i] & b_eff[i];
    assign prop_i      = a[i] ^ b_eff[i];
    assign sum[i]      = prop_i ^ carry[i];
    assign carry[i+1]  = gen_i | (prop_i & carry[i]);
  end

  assign cout = carry[WIDTH];

endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit
  import sm_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  sm_path_e         path,
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_ovf
);

  logic             is_sub;
  logic [MAG_W-1:0] raw;
  logic             carry_out;
  logic             borrow;
  logic [MAG_W-1:0] fixed_mag;
  logic             mag_zero;

  assign is_sub = (path == SM_PATH_SUB);

  sm_mag_adder #(.WIDTH(MAG_W)) adder_i (
    .a    (mag_a),
    .b    (mag_b),
    .sub  (is_sub),
    .sum  (raw),
    .cout (carry_out)
  );

  always_comb begin
    // on the subtract path a missing carry means the difference went negative
    borrow    = is_sub & ~carry_out;
    fixed_mag = borrow ? (~raw + {{(MAG_W-1){1'b0}}, 1'b1}) : raw;
    mag_zero  = (fixed_mag == '0);
    res_mag   = fixed_mag;
    res_ovf   = ~is_sub & carry_out;
    if (!is_sub) begin
      res_sign = sign_a;
    end else if (mag_zero) begin
      res_sign = 1'b0;
    end else begin
      res_sign = borrow ? ~sign_a : sign_a;
    end
  end

endmodule

// File: rtl/sm_out_stage.sv
module sm_out_stage #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = ~full_q | dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) begin
        data_q <= up_data;
      end
    end
  end

endmodule

// File: rtl/sm_addsub_unit.sv
module sm_addsub_unit
  import sm_pkg::*;
#(
  parameter int MAG_W = 7,
  localparam int OPND_W = MAG_W + 1,
  localparam int RES_W  = MAG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPND_W-1:0] in_a,
  input  logic [OPND_W-1:0] in_b,
  input  logic              in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sign,
  output logic [MAG_W-1:0]  out_mag,
  output logic              out_ovf
);

  sm_path_e         path;
  logic             c_sign;
  logic [MAG_W-1:0] c_mag;
  logic             c_ovf;
  logic [RES_W-1:0] c_pack;
  logic [RES_W-1:0] q_pack;

  sm_path_select sel_i (
    .sign_a (in_a[OPND_W-1]),
    .sign_b (in_b[OPND_W-1]),
    .op_sub (in_op),
    .path   (path)
  );

  sm_mag_unit #(.MAG_W(MAG_W)) mag_i (
    .path     (path),
    .sign_a   (in_a[OPND_W-1]),
    .mag_a    (in_a[MAG_W-1:0]),
    .mag_b    (in_b[MAG_W-1:0]),
    .res_sign (c_sign),
    .res_mag  (c_mag),
    .res_ovf  (c_ovf)
  );

  assign c_pack = {c_sign, c_ovf, c_mag};

  sm_out_stage #(.DATA_W(RES_W)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (c_pack),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (q_pack)
  );

  assign out_sign = q_pack[RES_W-1];
  assign out_ovf  = q_pack[RES_W-2];
  assign out_mag  = q_pack[MAG_W-1:0];

endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int MAG_W = 7,
  localparam int OPND_W = MAG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPND_W-1:0] in_a,
  input logic [OPND_W-1:0] in_b,
  input logic              in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sign,
  input logic [MAG_W-1:0]  out_mag,
  input logic              out_ovf
);

  logic take;
  logic par;
  assign take = in_valid & in_ready;
  assign par  = in_a[OPND_W-1] ^ in_b[OPND_W-1] ^ in_op;

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag)
                                   && $stable(out_sign) && $stable(out_ovf)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_add_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !par) |=> (out_sign == $past(in_a[OPND_W-1])));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && par) |=> !out_ovf);

  p_zero_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && par) |=> (out_mag != '0 || !out_sign));

endmodule

bind sm_addsub_unit sm_addsub_chk #(.MAG_W(MAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sign  (out_sign),
  .out_mag   (out_mag),
  .out_ovf   (out_ovf)
);

// File: tb/sm_addsub_unit_tb_top.sv
`timescale 1ns/1ps
module sm_addsub_unit_tb_top;

  localparam int MAG_W  = 7;
  localparam int OPND_W = MAG_W + 1;
  localparam int MAXMAG = (1 << MAG_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [OPND_W-1:0] in_a = '0;
  logic [OPND_W-1:0] in_b = '0;
  logic              in_op = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_sign;
  logic [MAG_W-1:0]  out_mag;
  logic              out_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  int ready_pct = 100;
  bit done = 1'b0;

  logic [MAG_W+1:0] exp_q[$];
  string            tag_q[$];

  always #4 clk = ~clk;

  sm_addsub_unit #(.MAG_W(MAG_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sign  (out_sign),
    .out_mag   (out_mag),
    .out_ovf   (out_ovf)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // integer reference: returns {sign, ovf, mag}
  function automatic logic [MAG_W+1:0] ref_model(logic sa, int ma, logic sb, int mb,
                                                  logic op, output string tag);
    int va, vb, r, am;
    logic par, s, v;
    par = sa ^ sb ^ op;
    va = sa ? -ma : ma;
    vb = sb ? -mb : mb;
    r  = op ? (va - vb) : (va + vb);
    am = (r < 0) ? -r : r;
    v  = 1'b0;
    if (r > 0) s = 1'b0;
    else if (r < 0) s = 1'b1;
    else s = par ? 1'b0 : sa;
    if (am > MAXMAG) begin
      v  = 1'b1;
      am = am % (MAXMAG + 1);
    end
    if (!par) tag = v ? "R3" : "R1 R2";
    else if (am == 0) tag = "R7 R6";
    else if (ma < mb) tag = "R5 R6";
    else tag = "R4 R6";
    if ((sa && ma == 0) || (sb && mb == 0)) tag = {tag, " R8"};
    return {s, v, am[MAG_W-1:0]};
  endfunction

  task automatic send(logic sa, int ma, logic sb, int mb, logic op);
    string t;
    logic [MAG_W+1:0] e;
    @(negedge clk);
    in_a = {sa, ma[MAG_W-1:0]};
    in_b = {sb, mb[MAG_W-1:0]};
    in_op = op;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e = ref_model(sa, ma, sb, mb, op, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
  endtask

  // consumer back-pressure
  always @(negedge clk) begin
    out_ready <= ($urandom_range(99) < ready_pct);
  end

  // monitor / scoreboard
  logic              stall_prev = 1'b0;
  logic [MAG_W+1:0]  held = '0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) begin
        n_cmp++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          n_bad++;
          $display("FAIL R10 reset: valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
        end
      end else begin
        if (stall_prev) begin
          n_cmp++;
          if (out_valid !== 1'b1 || {out_sign, out_ovf, out_mag} !== held) begin
            n_bad++;
            $display("FAIL R9 hold: valid=%b data=%h expected valid=1 data=%h",
                     out_valid, {out_sign, out_ovf, out_mag}, held);
          end
        end
        stall_prev = out_valid && !out_ready;
        held = {out_sign, out_ovf, out_mag};
        if (out_valid && out_ready) begin
          n_cmp++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected result: data=%h expected none", held);
          end else begin
            logic [MAG_W+1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (held !== e) begin
              n_bad++;
              $display("FAIL %s: sign/ovf/mag=%b/%b/%0d expected %b/%b/%0d",
                       t, out_sign, out_ovf, out_mag, e[MAG_W+1], e[MAG_W], e[MAG_W-1:0]);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: plain additions, both signs
    send(0, 5, 0, 3, 0);
    send(1, 20, 1, 7, 0);
    send(1, 9, 0, 4, 1);        // -9 - +4 : add path, sign of a
    send(1, 0, 1, 0, 0);        // R2 with zero magnitudes keeps sign 1
    // R3: overflow wraps
    send(0, 100, 0, 100, 0);
    send(1, MAXMAG, 0, 1, 1);
    send(0, 64, 0, 64, 0);      // wraps to exactly zero
    // R4: no borrow
    send(0, 50, 0, 20, 1);
    send(1, 30, 0, 10, 0);
    // R5: borrow recovery with sign flip
    send(0, 3, 0, 5, 1);
    send(1, 2, 0, 90, 0);
    send(0, 0, 0, MAXMAG, 1);
    // R7: zero difference gets positive sign
    send(1, 3, 1, 3, 1);
    send(0, 44, 1, 44, 0);
    // R8: negative zero inputs
    send(1, 0, 0, 0, 0);
    send(1, 0, 1, 0, 1);
    send(0, 12, 1, 0, 0);
    send(1, 0, 0, 6, 1);
    // R9: random operands under back-pressure
    ready_pct = 40;
    for (int i = 0; i < 400; i++) begin
      int ma, mb;
      ma = $urandom_range(MAXMAG);
      mb = (i % 7 == 0) ? ma : $urandom_range(MAXMAG);
      if (i % 11 == 0) ma = 0;
      send(1'($urandom_range(1)), ma, 1'($urandom_range(1)), mb, 1'($urandom_range(1)));
    end
    @(negedge clk);
    in_valid = 1'b0;
    ready_pct = 100;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule